// File: doc/BRIEF.md
# Hysteretic Cell Activation Sequencer

This block decides how many of a bank of identical, fixed-power converter cells are switched on. The cells share one output with a small trimming regulator. Two comparator flags report the regulator's output current. One flag means the current is above an upper limit, so more bulk power is needed. The other means it is below a lower limit, so there is too much bulk power. On each control tick the sequencer turns on one more cell or turns off one cell. It never changes more than one cell per tick, so a large load step is followed one cell per tick.

The set of active cells is held as a thermometer pattern: cells 0 through k-1 are on and all others are off. The pattern sits in a shift register that moves in either direction and is split into equal segments. Each cell enable is active-low. A separate count output and a conflict flag let the surrounding logic watch the block. The comparator flags arrive asynchronously and are synchronised inside the block. A clock-enable input turns a fast system clock into the slow control tick. The gap between the two comparator thresholds must be wider than one cell's current; otherwise the sequencer oscillates between two counts.

Top module: `cell_seq_top`

## Requirements
- R1: While `rst` is high and after it is released, every bit of `cell_en_n` is 1, `active_cnt` is 0 and `clash_err` is 0.
- R2: On a rising clock edge with `tick_en`=1, a synchronised upper flag and no lower flag, and fewer than NUM_CELLS cells on, the count rises by one. The newly enabled cell is the lowest-indexed cell that was off, so cells 0..k-1 stay the active set.
- R3: On a tick with a synchronised lower flag, no upper flag and at least one cell on, the highest-indexed active cell is disabled and the count falls by one.
- R4: Without `tick_en`, `cell_en_n` and `active_cnt` do not change whatever the flags are. Between two consecutive clocks at most one enable bit changes.
- R5: When all NUM_CELLS cells are on, an up request on a tick leaves all enables low and the count at NUM_CELLS.
- R6: When no cell is on, a down request on a tick leaves all enables high and the count at 0.
- R7: On a tick where both synchronised flags are 1, the enables and count hold and `clash_err` becomes 1. Each later tick rewrites `clash_err`, setting it to 1 only if both flags are 1 on that tick.
- R8: Each flag passes through a two-stage synchroniser. A flag level is acted on at a tick edge only if it was present at the two previous rising edges. A flag raised less than one clock before a tick is therefore ignored on that tick.
- R9: `active_cnt` always equals the number of 0 bits in `cell_en_n` and changes on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| tick_en | input | 1 | one-cycle control tick strobe |
| over_hi_async | input | 1 | asynchronous flag: trim current above upper limit |
| under_lo_async | input | 1 | asynchronous flag: trim current below lower limit |
| cell_en_n | output | NUM_CELLS | active-low cell enables, bit i drives cell i |
| active_cnt | output | $clog2(NUM_CELLS+1) | number of enabled cells |
| clash_err | output | 1 | both flags seen on the last tick |

## Verification
A corrupted shift register shows at the enables on the very next tick, and often at once. Symptoms are a pattern that is not a thermometer, a hole when a bit crosses the boundary between segments, or two enables flipping on one edge. The count and the enable pattern are checked against each other after every tick, so a counter that drifts away from the register shows up within one tick. A wrong synchroniser depth shows as a flag acted on one tick early. A bad limit check shows as the count wrapping past NUM_CELLS or below zero on the first out-of-range request.

// File: rtl/cell_seq_pkg.sv
package cell_seq_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_UP    = 2'd1,
    ACT_DOWN  = 2'd2,
    ACT_CLASH = 2'd3
  } seq_act_e;

  // Decide the step for one tick from the synchronised flags and range limits.
  function automatic seq_act_e pick_action(input logic tick, input logic hi,
                                           input logic lo, input logic full,
                                           input logic empty);
    seq_act_e a;
    a = ACT_HOLD;
    if (tick) begin
      if (hi && lo)           a = ACT_CLASH;
      else if (hi && !full)   a = ACT_UP;
      else if (lo && !empty)  a = ACT_DOWN;
    end
    return a;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/therm_seg.sv
module therm_seg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_up,
  input  logic         shift_dn,
  input  logic         fill_in,
  input  logic         drain_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_up) q <= {q[W-2:0], fill_in};
    else if (shift_dn) q <= {drain_in, q[W-1:1]};
  end

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q ^ $past(q)));
endmodule

// File: rtl/cell_seq_top.sv
module cell_seq_top
  import cell_seq_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int SEG_W     = 4,
  parameter int SYNC_LEN  = 2,
  localparam int NSEG     = NUM_CELLS / SEG_W,
  localparam int CNT_W    = $clog2(NUM_CELLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 over_hi_async,
  input  logic                 under_lo_async,
  output logic [NUM_CELLS-1:0] cell_en_n,
  output logic [CNT_W-1:0]     active_cnt,
  output logic                 clash_err
);
  logic [1:0]           flags_s;
  logic                 hi_s, lo_s;
  logic [NUM_CELLS-1:0] therm;
  logic                 full, empty;
  logic                 do_up, do_dn;
  seq_act_e             act;

  flag_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({over_hi_async, under_lo_async}),
    .dout (flags_s)
  );
  assign hi_s = flags_s[1];
  assign lo_s = flags_s[0];

  assign full  = therm[NUM_CELLS-1];
  assign empty = ~therm[0];
  assign act   = pick_action(tick_en, hi_s, lo_s, full, empty);
  assign do_up = (act == ACT_UP);
  assign do_dn = (act == ACT_DOWN);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic fill_w, drain_w;
    if (s == 0) begin : g_bot
      assign fill_w = 1'b1;
    end else begin : g_mid_lo
      assign fill_w = therm[s*SEG_W-1];
    end
    if (s == NSEG-1) begin : g_top
      assign drain_w = 1'b0;
    end else begin : g_mid_hi
      assign drain_w = therm[(s+1)*SEG_W];
    end
    therm_seg #(.W(SEG_W)) u_seg (
      .clk      (clk),
      .rst      (rst),
      .shift_up (do_up),
      .shift_dn (do_dn),
      .fill_in  (fill_w),
      .drain_in (drain_w),
      .q        (therm[s*SEG_W +: SEG_W])
    );
  end

  assign cell_en_n = ~therm;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_cnt <= '0;
      clash_err  <= 1'b0;
    end else begin
      if (do_up)      active_cnt <= active_cnt + 1'b1;
      else if (do_dn) active_cnt <= active_cnt - 1'b1;
      if (tick_en)    clash_err  <= (act == ACT_CLASH);
    end
  end

  // R1
  rst_off_chk: assert property (@(posedge clk) rst |=> (&cell_en_n) && active_cnt == '0);
  // R2
  therm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (therm & (therm + 1'b1)) == '0);
  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cell_en_n) && $stable(active_cnt));
  // R5
  full_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (active_cnt == CNT_W'(NUM_CELLS)) |=> active_cnt <= CNT_W'(NUM_CELLS));
  // R6
  empty_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (active_cnt == '0 && !hi_s) |=> active_cnt == '0);
  // R7
  clash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && hi_s && lo_s) |=> clash_err && $stable(cell_en_n));
  // R9
  cnt_match_chk: assert property (@(posedge clk) disable iff (rst)
    active_cnt == CNT_W'($countones(~cell_en_n)));
endmodule

// File: tb/cell_seq_top_tb.sv
module cell_seq_top_tb;
  localparam int N     = 8;
  localparam int CNT_W = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic hi = 1'b0;
  logic lo = 1'b0;
  logic [N-1:0]     cell_en_n;
  logic [CNT_W-1:0] active_cnt;
  logic             clash_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  cell_seq_top #(.NUM_CELLS(N), .SEG_W(4)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .over_hi_async(hi), .under_lo_async(lo),
    .cell_en_n(cell_en_n), .active_cnt(active_cnt), .clash_err(clash_err)
  );

  task automatic check(input string req, input int k, input bit err);
    logic [N-1:0] exp_en;
    exp_en = ~N'((64'd1 << k) - 64'd1);
    total++;
    if (cell_en_n !== exp_en || active_cnt !== CNT_W'(k) || clash_err !== err) begin
      bad++;
      $display("FAIL %s: en_n=%b cnt=%0d err=%b expected en_n=%b cnt=%0d err=%b",
               req, cell_en_n, active_cnt, clash_err, exp_en, k, err);
    end
  endtask

  // Present flags and let them settle through the synchroniser.
  task automatic set_flags(input bit h, input bit l);
    @(negedge clk); hi = h; lo = l;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_tick;
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 0, 0);

    // R8: flag raised together with the tick is not yet visible
    @(negedge clk); hi = 1'b1; tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    check("R8", 0, 0);

    // R2 and R9: climb one cell per tick
    set_flags(1, 0);
    for (int k = 1; k <= N; k++) begin
      pulse_tick();
      check("R2", k, 0);
    end
    // R5: up at full is ignored
    pulse_tick();
    check("R5", N, 0);
    pulse_tick();
    check("R5", N, 0);

    // R7: clash at full holds and flags
    set_flags(1, 1);
    pulse_tick();
    check("R7", N, 1);
    // R4: no tick, flag persists, nothing moves
    set_flags(0, 1);
    repeat (5) @(negedge clk);
    check("R4", N, 1);

    // R3: descend, clash error cleared by first clean tick
    for (int k = N - 1; k >= 0; k--) begin
      pulse_tick();
      check("R3", k, 0);
    end
    // R6: down at zero is ignored
    pulse_tick();
    check("R6", 0, 0);

    // R7 at mid counts across the segment boundary
    for (int m = 3; m <= 5; m++) begin
      set_flags(1, 0);
      while (active_cnt != CNT_W'(m)) pulse_tick();
      check("R2", m, 0);
      set_flags(1, 1);
      pulse_tick();
      check("R7", m, 1);
      set_flags(0, 0);
      pulse_tick();
      check("R7", m, 0);
    end

    // R8: lower flag raised with tick is ignored that tick, used the next ones
    @(negedge clk); lo = 1'b1; tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    check("R8", 5, 0);
    @(negedge clk);
    pulse_tick();
    check("R3", 4, 0);

    // R4: long idle with both flags high and no tick
    set_flags(1, 1);
    repeat (20) @(negedge clk);
    check("R4", 4, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule